// File: doc/BRIEF.md
# Data-Dependent Iterative Integer Multiplier

This block multiplies two 32-bit integers over several clock cycles, taking one 8-bit chunk of the multiplier operand per cycle. The scan stops once every chunk still ahead holds only sign or zero extension. Short multiplier values therefore finish sooner than wide ones. It produces 32-bit products, 32-bit multiply-accumulate, and 64-bit signed or unsigned products with an optional 64-bit addend. An operation that stops early is corrected in its first step for the all-ones chunks it skipped.

A caller raises `start` for one cycle while the block is idle and presents the opcode, operands, addend and flag request together with it. `busy` stays high for the whole operation. `done` pulses in its last cycle, with `result`, `cycles` and, when requested, the condition flags valid at that moment. `result` and `cycles` then hold until the next accepted start. The latency rules depend on the opcode. A separate input selects the compact-encoding variant of the plain 32-bit multiply, which recognises only zero extension.

Top module: `mulx_core`

## Requirements
- R1: A `start` seen while idle is accepted at that clock edge and `busy` is high in the next cycle. A `start` seen while `busy` is high is ignored: the running operation's result and latency are unaffected, and no second operation follows it.
- R2: Opcode 0 (32-bit multiply, `short_enc` low) takes 1 cycle when multiplier bits 31:8 are all zeros or all ones, 2 when bits 31:16 are, 3 when bits 31:24 are, and 4 otherwise.
- R3: Opcode 1 (32-bit multiply-accumulate) uses the R2 test plus one cycle, giving 2 to 5 cycles.
- R4: Opcodes 2 and 3 (unsigned 64-bit, without and with addend) shorten only on all-zero upper chunks. All-ones upper chunks give no benefit. Cost is chunks plus one, 2 to 5 cycles.
- R5: Opcodes 4 and 5 (signed 64-bit, without and with addend) shorten on all-zero or all-ones upper chunks. Cost is chunks plus one, 2 to 5 cycles.
- R6: Opcode 0 with `short_enc` high takes 4 cycles if bits 31:24 are nonzero, else 3 if bits 23:16 are nonzero, else 2 if bits 15:8 are nonzero, else 1.
- R7: Opcodes 0 and 1 give, in `result[31:0]`, the low 32 bits of the product, plus `acc_in[31:0]` for opcode 1. `result[63:32]` is zero.
- R8: Opcodes 2 to 5 give the full 64-bit product, with both operands unsigned (2, 3) or signed (4, 5). Opcodes 3 and 5 add all 64 bits of `acc_in`.
- R9: `busy` is high for exactly the operation's latency L in consecutive cycles. `done` is high in only the last of them. `cycles` equals L while `done` is high.
- R10: With `set_flags` high at start, `flag_we` is high together with `done`, and `flag_c` is 0. `flag_n` is result bit 31 (opcodes 0, 1) or bit 63 (opcodes 2 to 5). `flag_z` is high when the 32-bit or 64-bit result is zero. With `set_flags` low, `flag_we` stays low.
- R11: After reset, `busy`, `done` and `flag_we` are low, and `result` and `cycles` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | 0 mul, 1 mul-acc, 2 unsigned long, 3 unsigned long-acc, 4 signed long, 5 signed long-acc; 6 and 7 act as 0 |
| short_enc | input | 1 | Compact-encoding latency rule for opcode 0 |
| set_flags | input | 1 | Request flag update at completion |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier (scanned chunk by chunk) |
| acc_in | input | 64 | Addend for accumulate forms |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| result | output | 64 | Product or sum, valid with done and held |
| cycles | output | 3 | Latency of the last operation |
| flag_we | output | 1 | Flags valid and to be written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, forced low |

## Verification
The assertions assume that `start` has a known value from reset onward. They also assume that opcode and operands are stable in the cycle where `start` is sampled while idle. The bench drives every input on the falling edge and releases `start` one cycle after raising it, except in the deliberate mid-operation start. That case checks that a start seen during `busy` does not disturb the running operation. The operand set covers zero, all ones, 0xFF, 0x100, 0x80000000, and a value whose upper bits are all ones while bit 7 is clear, which exercises the skipped-chunk correction.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
   typedef enum logic [2:0] {
      OP_MUL   = 3'd0,
      OP_MLA   = 3'd1,
      OP_UMULL = 3'd2,
      OP_UMLAL = 3'd3,
      OP_SMULL = 3'd4,
      OP_SMLAL = 3'd5
   } mul_op_e;
endpackage

// File: rtl/mulx_span.sv
module mulx_span #(
   parameter int DW = 32,
   parameter int CW = 8,
   parameter int NW = 3
) (
   input  logic [DW-1:0] mplier,
   input  logic          zero_only,
   output logic [NW-1:0] nchunk,
   output logic          neg_ext
);
   localparam int NCH = DW / CW;

   logic [NCH-1:1] up_ok;

   generate
      if ((DW % CW) != 0 || NCH < 2) begin : g_bad_cfg
         $error("mulx_span: DW must be a multiple of CW with at least two chunks");
      end
      for (genvar k = 1; k < NCH; k++) begin : g_up
         logic all_zero, all_ones;
         assign all_zero = ~|mplier[DW-1:k*CW];
         assign all_ones = &mplier[DW-1:k*CW];
         assign up_ok[k] = all_zero | (~zero_only & all_ones);
      end
   endgenerate

   // upper-extension tests are monotone in k: the lowest passing k wins
   always_comb begin
      nchunk = NW'(NCH);
      for (int k = NCH - 1; k >= 1; k--) begin
         if (up_ok[k]) nchunk = NW'(k);
      end
   end

   // skipped chunks (or the top chunk when none skipped) stand for -1
   assign neg_ext = ~zero_only & mplier[DW-1];
endmodule

// File: rtl/mulx_pp.sv
module mulx_pp #(
   parameter int DW = 32,
   parameter int CW = 8,
   parameter int IW = 2
) (
   input  logic [2*DW-1:0] mcand_ext,
   input  logic [DW-1:0]   mplier,
   input  logic [IW-1:0]   idx,
   output logic [2*DW-1:0] pp
);
   localparam int RW = 2 * DW;

   logic [CW-1:0] chunk;
   logic [RW-1:0] prod;

   generate
      if (CW >= DW) begin : g_bad_cfg
         $error("mulx_pp: chunk must be narrower than the operand");
      end
   endgenerate

   assign chunk = mplier[idx*CW +: CW];
   assign prod  = mcand_ext * {{(RW-CW){1'b0}}, chunk};
   assign pp    = prod << (idx * CW);
endmodule

// File: rtl/mulx_flag.sv
module mulx_flag #(
   parameter int DW = 32
) (
   input  logic [2*DW-1:0] result,
   input  logic            long_res,
   output logic            neg,
   output logic            zero
);
   always_comb begin
      if (long_res) begin
         neg  = result[2*DW-1];
         zero = (result == '0);
      end else begin
         neg  = result[DW-1];
         zero = (result[DW-1:0] == '0);
      end
   end
endmodule

// File: rtl/mulx_core.sv
module mulx_core #(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start,
   input  logic [2:0]                           op,
   input  logic                                 short_enc,
   input  logic                                 set_flags,
   input  logic [DATA_W-1:0]                    mcand,
   input  logic [DATA_W-1:0]                    mplier,
   input  logic [2*DATA_W-1:0]                  acc_in,
   output logic                                 busy,
   output logic                                 done,
   output logic [2*DATA_W-1:0]                  result,
   output logic [$clog2(DATA_W/CHUNK_W+2)-1:0]  cycles,
   output logic                                 flag_we,
   output logic                                 flag_n,
   output logic                                 flag_z,
   output logic                                 flag_c
);
   import mulx_pkg::*;

   localparam int NCH = DATA_W / CHUNK_W;
   localparam int RW  = 2 * DATA_W;
   localparam int NW  = $clog2(NCH + 1);
   localparam int LW  = $clog2(NCH + 2);
   localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (DATA_W % CHUNK_W != 0 || NCH < 2) begin : g_bad_cfg
         $error("mulx_core: DATA_W must split into two or more chunks");
      end
   endgenerate

   // opcode decode
   logic is_long, is_acc_long, is_mla, is_sgn_long, has_extra, zero_only;
   always_comb begin
      is_long     = (op == OP_UMULL) || (op == OP_UMLAL) ||
                    (op == OP_SMULL) || (op == OP_SMLAL);
      is_acc_long = (op == OP_UMLAL) || (op == OP_SMLAL);
      is_mla      = (op == OP_MLA);
      is_sgn_long = (op == OP_SMULL) || (op == OP_SMLAL);
      has_extra   = is_long || is_mla;
      zero_only   = (op == OP_UMULL) || (op == OP_UMLAL) ||
                    ((op == OP_MUL) && short_enc);
   end

   // latency from operand extension
   logic [NW-1:0] nch_in;
   logic          neg_in;
   logic [LW-1:0] lat_in;

   mulx_span #(.DW(DATA_W), .CW(CHUNK_W), .NW(NW)) u_span (
      .mplier    (mplier),
      .zero_only (zero_only),
      .nchunk    (nch_in),
      .neg_ext   (neg_in)
   );

   assign lat_in = LW'(nch_in) + LW'(has_extra);

   // operand preparation
   logic [RW-1:0] mcand_ext_in, acc_init, corr;
   always_comb begin
      mcand_ext_in = is_sgn_long ? {{DATA_W{mcand[DATA_W-1]}}, mcand}
                                 : {{DATA_W{1'b0}}, mcand};
      if (is_acc_long)  acc_init = acc_in;
      else if (is_mla)  acc_init = {{DATA_W{1'b0}}, acc_in[DATA_W-1:0]};
      else              acc_init = '0;
      corr = neg_in ? (mcand_ext_in << (nch_in * CHUNK_W)) : '0;
   end

   // sequencing state
   logic              busy_q, long_q, sf_q;
   logic [LW-1:0]     cyc_q, lat_q, cyc_nxt;
   logic [NW-1:0]     nch_q;
   logic [RW-1:0]     mcand_q, acc_q;
   logic [DATA_W-1:0] mplier_q;

   assign cyc_nxt = cyc_q + 1'b1;

   // one shared partial-product unit: chunk 0 at start, then the rest
   logic [RW-1:0]     pp, pp_mcand;
   logic [DATA_W-1:0] pp_mplier;
   logic [IW-1:0]     pp_idx;

   assign pp_mcand  = busy_q ? mcand_q  : mcand_ext_in;
   assign pp_mplier = busy_q ? mplier_q : mplier;
   assign pp_idx    = busy_q ? cyc_nxt[IW-1:0] : '0;

   mulx_pp #(.DW(DATA_W), .CW(CHUNK_W), .IW(IW)) u_pp (
      .mcand_ext (pp_mcand),
      .mplier    (pp_mplier),
      .idx       (pp_idx),
      .pp        (pp)
   );

   logic done_w;
   assign done_w = busy_q && (cyc_q == lat_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         long_q   <= 1'b0;
         sf_q     <= 1'b0;
         cyc_q    <= '0;
         lat_q    <= '0;
         nch_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q   <= 1'b1;
            long_q   <= is_long;
            sf_q     <= set_flags;
            cyc_q    <= '0;
            lat_q    <= lat_in;
            nch_q    <= nch_in;
            mcand_q  <= mcand_ext_in;
            mplier_q <= mplier;
            acc_q    <= acc_init + pp - corr;
         end
      end else begin
         cyc_q <= cyc_nxt;
         if (cyc_nxt < LW'(nch_q)) acc_q <= acc_q + pp;
         if (done_w) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign done    = done_w;
   assign cycles  = lat_q;
   assign result  = long_q ? acc_q : {{DATA_W{1'b0}}, acc_q[DATA_W-1:0]};
   assign flag_we = done_w & sf_q;
   assign flag_c  = 1'b0;

   mulx_flag #(.DW(DATA_W)) u_flag (
      .result   (result),
      .long_res (long_q),
      .neg      (flag_n),
      .zero     (flag_z)
   );

   // R1
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> busy_q);
   // R1
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done_w) |=> (busy_q && $stable(lat_q) && $stable(mplier_q)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_w |=> !done_w);
   // R9
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_w |=> !busy_q);
   // R2
   lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (lat_q >= 1 && int'(lat_q) <= NCH + 1 && cyc_q < lat_q));
   // R10
   flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !flag_we);
endmodule

// File: tb/tb_mulx_core.sv
module tb_mulx_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        short_enc = 1'b0;
   logic        set_flags = 1'b0;
   logic [31:0] mcand = '0;
   logic [31:0] mplier = '0;
   logic [63:0] acc_in = '0;
   logic        busy, done, flag_we, flag_n, flag_z, flag_c;
   logic [63:0] result;
   logic [2:0]  cycles;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mulx_core dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .short_enc(short_enc),
      .set_flags(set_flags), .mcand(mcand), .mplier(mplier), .acc_in(acc_in),
      .busy(busy), .done(done), .result(result), .cycles(cycles),
      .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit ext_ok(input logic [31:0] v, input int lo);
      logic [31:0] up;
      up = v >> lo;
      return (up == 0) || (up == ((32'hFFFF_FFFF) >> lo));
   endfunction

   function automatic int ref_lat(input logic [2:0] o, input logic se, input logic [31:0] b);
      int n;
      bit zonly;
      zonly = (o == 3'd2) || (o == 3'd3) || (o == 3'd0 && se);
      if (zonly) begin
         if (b[31:24] != 0) n = 4;
         else if (b[23:16] != 0) n = 3;
         else if (b[15:8] != 0) n = 2;
         else n = 1;
      end else begin
         if (ext_ok(b, 8)) n = 1;
         else if (ext_ok(b, 16)) n = 2;
         else if (ext_ok(b, 24)) n = 3;
         else n = 4;
      end
      return n + ((o == 3'd0) ? 0 : 1);
   endfunction

   function automatic logic [63:0] ref_res(input logic [2:0] o, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
      logic [31:0] lo;
      logic [63:0] ua, ub, sa, sb;
      ua = {32'b0, a};
      ub = {32'b0, b};
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      case (o)
         3'd1: begin lo = a * b + acc[31:0]; return {32'b0, lo}; end
         3'd2: return ua * ub;
         3'd3: return ua * ub + acc;
         3'd4: return sa * sb;
         3'd5: return sa * sb + acc;
         default: begin lo = a * b; return {32'b0, lo}; end
      endcase
   endfunction

   task automatic do_op(input string req, input logic [2:0] o, input logic se,
                        input logic sf, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] acc, input bit intrude);
      int exp_l, busy_cnt, done_cnt, done_at;
      logic [63:0] exp_r, r_at;
      logic [2:0] cyc_at;
      logic we_at, n_at, z_at, c_at, exp_n, exp_z, long_op;
      exp_l = ref_lat(o, se, b);
      exp_r = ref_res(o, a, b, acc);
      long_op = (o >= 3'd2) && (o <= 3'd5);
      exp_n = long_op ? exp_r[63] : exp_r[31];
      exp_z = long_op ? (exp_r == 0) : (exp_r[31:0] == 0);
      busy_cnt = 0; done_cnt = 0; done_at = 0;
      r_at = '0; cyc_at = '0; we_at = 0; n_at = 0; z_at = 0; c_at = 0;
      @(negedge clk);
      op = o; short_enc = se; set_flags = sf; mcand = a; mplier = b; acc_in = acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 12; i++) begin
         if (!busy) break;
         busy_cnt++;
         if (done) begin
            done_cnt++;
            done_at = busy_cnt;
            r_at = result; cyc_at = cycles;
            we_at = flag_we; n_at = flag_n; z_at = flag_z; c_at = flag_c;
         end
         if (intrude && i == 1) begin
            start = 1'b1; op = 3'd0; mplier = 32'h0; mcand = 32'h7; set_flags = 1'b0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(req, "busy cycles", 64'(busy_cnt), 64'(exp_l));
      check("R9", "done count", 64'(done_cnt), 64'd1);
      check("R9", "done position", 64'(done_at), 64'(busy_cnt));
      check("R9", "cycles port", 64'(cyc_at), 64'(exp_l));
      check(long_op ? "R8" : "R7", "result", r_at, exp_r);
      check("R10", "flag_we", 64'(we_at), 64'(sf));
      if (sf) begin
         check("R10", "flag_n", 64'(n_at), 64'(exp_n));
         check("R10", "flag_z", 64'(z_at), 64'(exp_z));
         check("R10", "flag_c", 64'(c_at), 64'd0);
      end
      if (intrude) begin
         @(negedge clk);
         @(negedge clk);
         check("R1", "no second op", 64'(busy), 64'd0);
         check("R1", "result held", result, exp_r);
         check("R1", "latency held", 64'(cycles), 64'(exp_l));
      end
   endtask

   task automatic t_reset();
      check("R11", "busy", 64'(busy), 64'd0);
      check("R11", "done", 64'(done), 64'd0);
      check("R11", "flag_we", 64'(flag_we), 64'd0);
      check("R11", "result", result, 64'd0);
      check("R11", "cycles", 64'(cycles), 64'd0);
   endtask

   task automatic t_mul();
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0000, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'h1234_5678, 32'hFFFF_FFFF, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0000_00FF, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0100, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'h0BAD_F00D, 32'hFFFF_FF7F, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'h7654_3210, 32'hFF81_2345, 64'd0, 0);
      do_op("R2", 3'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 64'd0, 0);
   endtask

   task automatic t_mla();
      do_op("R3", 3'd1, 1'b0, 1'b0, 32'h0000_1111, 32'h0000_0042, 64'hAAAA_0000_0000_0005, 0);
      do_op("R3", 3'd1, 1'b0, 1'b0, 32'h89AB_CDEF, 32'h1234_5678, 64'h0000_0000_FFFF_FFFF, 0);
   endtask

   task automatic t_ulong();
      do_op("R4", 3'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0);
      do_op("R4", 3'd2, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_00FF, 64'd0, 0);
      do_op("R4", 3'd3, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0100, 64'hFFFF_FFFF_0000_0001, 0);
      do_op("R4", 3'd3, 1'b0, 1'b0, 32'hCAFE_BABE, 32'h00FF_0000, 64'h0123_4567_89AB_CDEF, 0);
   endtask

   task automatic t_slong();
      do_op("R5", 3'd4, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0);
      do_op("R5", 3'd4, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 64'd0, 0);
      do_op("R5", 3'd4, 1'b0, 1'b0, 32'h1234_5678, 32'hFFFF_8001, 64'd0, 0);
      do_op("R5", 3'd5, 1'b0, 1'b0, 32'hFFFF_FF00, 32'h0000_0100, 64'h0000_0000_0000_1000, 0);
      do_op("R5", 3'd5, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FF7F, 64'h8000_0000_0000_0000, 0);
   endtask

   task automatic t_compact();
      do_op("R6", 3'd0, 1'b1, 1'b0, 32'h0000_0005, 32'hFFFF_FFFF, 64'd0, 0);
      do_op("R6", 3'd0, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_00FF, 64'd0, 0);
      do_op("R6", 3'd0, 1'b1, 1'b0, 32'h0000_0005, 32'h0001_0000, 64'd0, 0);
      do_op("R6", 3'd0, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_0100, 64'd0, 0);
   endtask

   task automatic t_flags();
      do_op("R10", 3'd0, 1'b0, 1'b1, 32'h0000_0000, 32'h1234_5678, 64'd0, 0);
      do_op("R10", 3'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 64'd0, 0);
      do_op("R10", 3'd4, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 64'd0, 0);
      do_op("R10", 3'd2, 1'b0, 1'b1, 32'h0001_0000, 32'h0001_0000, 64'd0, 0);
      do_op("R10", 3'd1, 1'b1, 1'b1, 32'h0000_0001, 32'h0000_0001, 64'h0000_0000_FFFF_FFFF, 0);
   endtask

   task automatic t_busy_ignore();
      do_op("R1", 3'd5, 1'b0, 1'b0, 32'h0F0F_0F0F, 32'h1234_5678, 64'h1111_2222_3333_4444, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mul();
      t_mla();
      t_ulong();
      t_slong();
      t_compact();
      t_flags();
      t_busy_ignore();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule